// File: doc/BRIEF.md
# Endian-Aware Load/Store Lane Aligner

This block sits between a processor's load/store pipeline and a 64-bit memory port. It moves data between register order and the byte lanes of an aligned 8-byte element. On a load it places the bytes read from memory into the lanes they belong in. On a store it returns element data to the low-order bytes. For both it produces a byte-enable mask that marks the lanes involved. On an instruction fetch it extracts a halfword or word from the element. The 16-byte quadword access passes both 64-bit halves through untouched.

Accesses may be 1 to 8 bytes long, and odd sizes such as 3, 5, 6 and 7 bytes are allowed. Big-endian and little-endian lane orders are both supported, together with an address swizzle for reverse-endian operation. The block flags any access that would run past the end of the 8-byte element, and any misaligned fetch. Each result is registered once behind a valid/ready handshake, and the error flags travel with the data.

Top module: `lane_aligner`

## Requirements
- R1: `in_op` selects the operation: 0 is load, 1 is store, 2 is fetch, and 3 behaves as a load. `in_len` holds the byte count minus one, so codes 0 to 7 mean 1 to 8 bytes and code 8 means a 16-byte quadword. Codes 9 to 15 are illegal; they raise `out_align_err`, drive zero data and zero byte enables, and return `out_addr` equal to `in_addr`.
- R2: For a non-quadword access with `in_rev` set, the effective offset becomes `in_addr ^ (7 ^ len)`. It is returned on `out_addr` and used by loads and stores. Otherwise `out_addr` equals `in_addr`.
- R3: A load or store raises `out_align_err` when the effective offset plus the length code exceeds 7. In that case data and byte enables are zero.
- R4: A big-endian load takes the low len+1 bytes of `in_data_lo` and shifts them left by 8*(7 - offset - len) bits.
- R5: A little-endian load takes the low len+1 bytes of `in_data_lo` and shifts them left by 8*offset bits.
- R6: A store shifts `in_data_lo` right by the same byte amount a load of the same shape would use, then keeps only the low len+1 bytes.
- R7: For loads and stores without error, `out_be` is (2^(len+1) - 1) shifted left by the byte shift of R4, R5 or R6, so exactly len+1 bits are set.
- R8: A quadword access copies `in_data_lo` and `in_data_hi` unchanged, sets `out_be` to all ones, raises no error and returns `out_addr` equal to `in_addr`. Every other access drives `out_data_hi` to zero.
- R9: A fetch raises `out_fetch_err` when `in_addr & len[2:0]` is nonzero. Its data and byte enables are then zero.
- R10: A fetch without error returns `in_data_lo` shifted right by 8*p bits and masked to len+1 bytes. Here p = `in_addr ^ a`, where a is 7^len in big-endian mode and 0 otherwise. `out_be` is (2^(len+1) - 1) << p, truncated to 8 bits, and a fetch never raises `out_align_err`.
- R11: `in_ready` is high whenever the output register is empty or `out_ready` is high. A request accepted at a clock edge appears on the outputs right after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold steady.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 2 | Operation: 0 load, 1 store, 2 fetch, 3 load |
| in_addr | input | 3 | Byte offset of the access within the 8-byte element |
| in_len | input | 4 | Byte count minus one; 8 selects quadword |
| in_big | input | 1 | Big-endian lane order |
| in_rev | input | 1 | Reverse-endian address swizzle enable |
| in_data_lo | input | 64 | Memory element (load, fetch) or register data (store), low half of a quadword |
| in_data_hi | input | 64 | High half of a quadword |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data_lo | output | 64 | Aligned data, low half |
| out_data_hi | output | 64 | Quadword high half, else zero |
| out_be | output | 8 | Byte lanes covered by the access |
| out_addr | output | 3 | Effective offset after the swizzle |
| out_align_err | output | 1 | Access crosses the element or illegal length |
| out_fetch_err | output | 1 | Misaligned instruction fetch |

## Verification
Every result, error flags included, is due on the outputs exactly one rising edge after the request is accepted. The bench drives each request at a falling edge and compares all outputs at the next falling edge, which lies between that acceptance edge and the next one. With `out_ready` held high, the sweep covers every combination of operation, length code, offset, lane order and swizzle, streaming one request per cycle. A separate backpressure case stalls the output and checks that the held result stays unchanged for several cycles and that the queued request appears one edge after the stall is released.

// File: rtl/lane_pkg.sv
package lane_pkg;

    parameter int ELEM_BYTES = 8;
    parameter int BYTE_W     = 8;
    localparam int ELEM_W    = ELEM_BYTES * BYTE_W;
    localparam int OFS_W     = $clog2(ELEM_BYTES);
    localparam int LEN_W     = OFS_W + 1;
    localparam int BYTE_SH   = $clog2(BYTE_W);
    localparam int SH_W      = OFS_W + BYTE_SH;
    localparam int QUAD_CODE = ELEM_BYTES;
    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(ELEM_BYTES - 1);

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FETCH = 2'd2,
        OP_LOAD2 = 2'd3
    } op_e;

    // request fields that steer lane selection
    typedef struct packed {
        op_e              op;
        logic [OFS_W-1:0] ofs;
        logic [LEN_W-1:0] len;
        logic             big;
        logic             rev;
    } cmd_t;

    // decoded control for the data mover
    typedef struct packed {
        logic             quad;
        logic [OFS_W-1:0] code;
        logic [OFS_W-1:0] ofs_eff;
        logic [OFS_W-1:0] lane;
        logic             align_err;
        logic             fetch_err;
    } ctl_t;

    // registered result
    typedef struct packed {
        logic [ELEM_W-1:0]     lo;
        logic [ELEM_W-1:0]     hi;
        logic [ELEM_BYTES-1:0] be;
        logic [OFS_W-1:0]      addr;
        logic                  align_err;
        logic                  fetch_err;
    } res_t;

    // reverse-endian offset swizzle
    function automatic logic [OFS_W-1:0] swizzle(input logic [OFS_W-1:0] ofs,
                                                 input logic [OFS_W-1:0] code);
        return ofs ^ (OFS_MAX ^ code);
    endfunction

    // true when the access runs past the last byte of the element
    function automatic logic crosses(input logic [OFS_W-1:0] ofs,
                                     input logic [OFS_W-1:0] code);
        logic [OFS_W:0] sum;
        sum = {1'b0, ofs} + {1'b0, code};
        return sum > {1'b0, OFS_MAX};
    endfunction

endpackage

// File: rtl/lane_ctl.sv
module lane_ctl
    import lane_pkg::*;
(
    input  cmd_t cmd,
    output ctl_t ctl
);

    logic             quad;
    logic             bad;
    logic             is_fetch;
    logic [OFS_W-1:0] code;
    logic [OFS_W-1:0] big_adj;
    logic [OFS_W-1:0] ofs_eff;

    always_comb begin
        code     = cmd.len[OFS_W-1:0];
        quad     = (cmd.len == LEN_W'(QUAD_CODE));
        bad      = (cmd.len > LEN_W'(QUAD_CODE));
        is_fetch = (cmd.op == OP_FETCH);
        big_adj  = cmd.big ? (OFS_MAX ^ code) : '0;
        ofs_eff  = (cmd.rev && !quad && !bad) ? swizzle(cmd.ofs, code) : cmd.ofs;

        ctl           = '0;
        ctl.quad      = quad;
        ctl.code      = code;
        ctl.ofs_eff   = ofs_eff;
        ctl.fetch_err = is_fetch && !quad && !bad && ((cmd.ofs & code) != '0);
        ctl.align_err = bad || (!is_fetch && !quad && crosses(ofs_eff, code));

        if (is_fetch)
            ctl.lane = cmd.ofs ^ big_adj;
        else if (cmd.big)
            ctl.lane = OFS_MAX - ofs_eff - code;
        else
            ctl.lane = ofs_eff;
    end

endmodule

// File: rtl/lane_mover.sv
module lane_mover
    import lane_pkg::*;
(
    input  op_e               op,
    input  logic [ELEM_W-1:0] data_lo,
    input  logic [ELEM_W-1:0] data_hi,
    input  ctl_t              ctl,
    output res_t              res
);

    logic [ELEM_BYTES-1:0] keep;
    logic [ELEM_W-1:0]     dmask;
    logic [SH_W-1:0]       shamt;

    // byte i takes part when its index does not exceed the length code
    for (genvar i = 0; i < ELEM_BYTES; i++) begin : g_lane
        assign keep[i]                    = (OFS_W'(i) <= ctl.code);
        assign dmask[i*BYTE_W +: BYTE_W]  = {BYTE_W{keep[i]}};
    end

    assign shamt = SH_W'(ctl.lane) << BYTE_SH;

    always_comb begin
        res           = '0;
        res.addr      = ctl.ofs_eff;
        res.align_err = ctl.align_err;
        res.fetch_err = ctl.fetch_err;
        if (ctl.quad) begin
            res.lo = data_lo;
            res.hi = data_hi;
            res.be = '1;
        end else if (ctl.align_err || ctl.fetch_err) begin
            res.lo = '0;
            res.be = '0;
        end else if (op == OP_STORE || op == OP_FETCH) begin
            res.lo = (data_lo >> shamt) & dmask;
            res.be = keep << ctl.lane;
        end else begin
            res.lo = (data_lo & dmask) << shamt;
            res.be = keep << ctl.lane;
        end
    end

endmodule

// File: rtl/lane_pipe.sv
module lane_pipe
    import lane_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  res_t d,
    output logic out_valid,
    input  logic out_ready,
    output res_t q
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else begin
            if (in_ready)
                out_valid <= in_valid;
            if (in_valid && in_ready)
                q <= d;
        end
    end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import lane_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [1:0]            in_op,
    input  logic [OFS_W-1:0]      in_addr,
    input  logic [LEN_W-1:0]      in_len,
    input  logic                  in_big,
    input  logic                  in_rev,
    input  logic [ELEM_W-1:0]     in_data_lo,
    input  logic [ELEM_W-1:0]     in_data_hi,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ELEM_W-1:0]     out_data_lo,
    output logic [ELEM_W-1:0]     out_data_hi,
    output logic [ELEM_BYTES-1:0] out_be,
    output logic [OFS_W-1:0]      out_addr,
    output logic                  out_align_err,
    output logic                  out_fetch_err
);

    cmd_t cmd;
    ctl_t ctl;
    res_t res_d;
    res_t res_q;

    always_comb begin
        cmd.op  = op_e'(in_op);
        cmd.ofs = in_addr;
        cmd.len = in_len;
        cmd.big = in_big;
        cmd.rev = in_rev;
    end

    lane_ctl u_ctl (
        .cmd (cmd),
        .ctl (ctl)
    );

    lane_mover u_mover (
        .op      (cmd.op),
        .data_lo (in_data_lo),
        .data_hi (in_data_hi),
        .ctl     (ctl),
        .res     (res_d)
    );

    lane_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (res_q)
    );

    assign out_data_lo   = res_q.lo;
    assign out_data_hi   = res_q.hi;
    assign out_be        = res_q.be;
    assign out_addr      = res_q.addr;
    assign out_align_err = res_q.align_err;
    assign out_fetch_err = res_q.fetch_err;

endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk
    import lane_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [1:0]            in_op,
    input logic [OFS_W-1:0]      in_addr,
    input logic [LEN_W-1:0]      in_len,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [ELEM_W-1:0]     out_data_lo,
    input logic [ELEM_W-1:0]     out_data_hi,
    input logic [ELEM_BYTES-1:0] out_be,
    input logic                  out_align_err,
    input logic                  out_fetch_err
);

    logic take;
    assign take = in_valid && in_ready;

    assert_ready_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    assert_hold_stalled_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data_lo)
                                       && $stable(out_data_hi) && $stable(out_be)));

    assert_align_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_align_err) |-> (out_be == '0 && out_data_lo == '0));

    assert_store_be_count_R7: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == 2'd1 && in_len < LEN_W'(QUAD_CODE))
        |=> (out_align_err || $countones(out_be) == int'($past(in_len)) + 1));

    assert_quad_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (take && in_len == LEN_W'(QUAD_CODE))
        |=> (out_be == '1 && !out_align_err && !out_fetch_err));

    assert_fetch_misalign_R9: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == 2'd2 && in_len < LEN_W'(QUAD_CODE)
         && (in_addr & in_len[OFS_W-1:0]) != '0)
        |=> (out_fetch_err && out_be == '0));

    assert_hi_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (take && in_len != LEN_W'(QUAD_CODE)) |=> (out_data_hi == '0));

endmodule

bind lane_aligner lane_aligner_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_op         (in_op),
    .in_addr       (in_addr),
    .in_len        (in_len),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data_lo   (out_data_lo),
    .out_data_hi   (out_data_hi),
    .out_be        (out_be),
    .out_align_err (out_align_err),
    .out_fetch_err (out_fetch_err)
);

// File: tb/tb_lane_aligner.sv
`timescale 1ns/1ps
module tb_lane_aligner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [2:0]  in_addr = '0;
    logic [3:0]  in_len = '0;
    logic        in_big = 1'b0;
    logic        in_rev = 1'b0;
    logic [63:0] in_data_lo = '0;
    logic [63:0] in_data_hi = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data_lo;
    logic [63:0] out_data_hi;
    logic [7:0]  out_be;
    logic [2:0]  out_addr;
    logic        out_align_err;
    logic        out_fetch_err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lane_aligner dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .in_len(in_len), .in_big(in_big),
        .in_rev(in_rev), .in_data_lo(in_data_lo), .in_data_hi(in_data_hi),
        .out_valid(out_valid), .out_ready(out_ready), .out_data_lo(out_data_lo),
        .out_data_hi(out_data_hi), .out_be(out_be), .out_addr(out_addr),
        .out_align_err(out_align_err), .out_fetch_err(out_fetch_err)
    );

    // expected outputs
    logic [63:0] e_lo, e_hi;
    logic [7:0]  e_be;
    logic [2:0]  e_addr;
    logic        e_al, e_fe;
    string       e_tag;

    task automatic model(input int op, input int len, input int ofs, input int big,
                         input int rev, input logic [63:0] lo, input logic [63:0] hi);
        int oe, nb, s, p;
        logic [64:0] m65;
        logic [63:0] m;
        int bm;
        e_lo = '0; e_hi = '0; e_be = '0; e_addr = 3'(ofs); e_al = 0; e_fe = 0;
        if (len == 8) begin
            e_lo = lo; e_hi = hi; e_be = 8'hFF; e_tag = "R8"; return;
        end
        if (len > 8) begin
            e_al = 1; e_tag = "R1"; return;
        end
        oe = (rev != 0) ? (ofs ^ (7 ^ len)) : ofs;
        e_addr = 3'(oe);
        nb  = len + 1;
        m65 = (65'd1 << (8 * nb)) - 65'd1;
        m   = m65[63:0];
        bm  = (1 << nb) - 1;
        if (op == 2) begin
            if ((ofs & len) != 0) begin
                e_fe = 1; e_tag = "R9"; return;
            end
            p = ofs ^ ((big != 0) ? (7 ^ len) : 0);
            e_lo = (lo >> (8 * p)) & m;
            e_be = 8'((bm << p) & 255);
            e_tag = "R10";
            return;
        end
        if (oe + len > 7) begin
            e_al = 1; e_tag = "R3"; return;
        end
        s = (big != 0) ? (7 - oe - len) : oe;
        e_be = 8'(bm << s);
        if (op == 1) begin
            e_lo = (lo >> (8 * s)) & m; e_tag = "R6";
        end else begin
            e_lo = (lo & m) << (8 * s); e_tag = (big != 0) ? "R4" : "R5";
        end
        if (rev != 0) e_tag = {e_tag, " R2"};
    endtask

    task automatic check_outputs();
        checks++;
        if (out_valid !== 1'b1 || out_data_lo !== e_lo || out_data_hi !== e_hi ||
            out_addr !== e_addr || out_align_err !== e_al || out_fetch_err !== e_fe) begin
            fails++;
            $display("FAIL %s op=%0d len=%0d addr=%0d big=%0d rev=%0d: got v=%0b lo=%h hi=%h a=%0d al=%0b fe=%0b exp lo=%h hi=%h a=%0d al=%0b fe=%0b",
                     e_tag, in_op, in_len, in_addr, in_big, in_rev, out_valid, out_data_lo,
                     out_data_hi, out_addr, out_align_err, out_fetch_err,
                     e_lo, e_hi, e_addr, e_al, e_fe);
        end
        checks++;
        if (out_be !== e_be) begin
            fails++;
            $display("FAIL R7 (%s) byte enables: got %b exp %b", e_tag, out_be, e_be);
        end
    endtask

    task automatic sweep(input logic [63:0] lo, input logic [63:0] hi);
        for (int op = 0; op < 4; op++)
            for (int len = 0; len < 16; len++)
                for (int ofs = 0; ofs < 8; ofs++)
                    for (int big = 0; big < 2; big++)
                        for (int rev = 0; rev < 2; rev++) begin
                            @(negedge clk);
                            in_valid   = 1'b1;
                            in_op      = 2'(op);
                            in_len     = 4'(len);
                            in_addr    = 3'(ofs);
                            in_big     = 1'(big);
                            in_rev     = 1'(rev);
                            in_data_lo = lo;
                            in_data_hi = hi;
                            model(op, len, ofs, big, rev, lo, hi);
                            @(negedge clk);
                            check_outputs();
                        end
        in_valid = 1'b0;
    endtask

    task automatic flag(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog expired: got hung run exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] hold_lo;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        flag(out_valid == 1'b0, $sformatf("R12 out_valid after reset: got %0b exp 0", out_valid));
        flag(in_ready == 1'b1, $sformatf("R12 in_ready after reset: got %0b exp 1", in_ready));

        // R1..R10 full sweep with two data patterns
        sweep(64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9900);
        sweep(64'hF0E1_D2C3_B4A5_9687, 64'h0123_4567_89AB_CDEF);

        // R11 backpressure: stall, hold, then release
        @(negedge clk);
        out_ready  = 1'b0;
        in_valid   = 1'b1;
        in_op      = 2'd0; in_len = 4'd3; in_addr = 3'd4; in_big = 1'b0; in_rev = 1'b0;
        in_data_lo = 64'h0000_0000_A1B2_C3D4;
        in_data_hi = '0;
        @(negedge clk);
        hold_lo = 64'hA1B2_C3D4_0000_0000;
        flag(out_valid && out_data_lo == hold_lo,
             $sformatf("R11 first result: got v=%0b %h exp 1 %h", out_valid, out_data_lo, hold_lo));
        flag(in_ready == 1'b0, $sformatf("R11 in_ready while stalled: got %0b exp 0", in_ready));
        in_op = 2'd1; in_len = 4'd1; in_addr = 3'd2;
        in_data_lo = 64'h0000_0000_00BE_EF00;
        repeat (3) @(negedge clk);
        flag(out_valid && out_data_lo == hold_lo && out_be == 8'hF0,
             $sformatf("R11 held result: got %h be=%b exp %h be=11110000", out_data_lo, out_be, hold_lo));
        out_ready = 1'b1;
        @(negedge clk);
        // store len1 ofs2 little: shift right 2 bytes, keep 2 bytes
        flag(out_valid && out_data_lo == 64'h0000_0000_0000_00BE && out_be == 8'b0000_1100,
             $sformatf("R11 queued result: got %h be=%b exp 00000000000000be be=00001100", out_data_lo, out_be));
        in_valid = 1'b0;
        @(negedge clk);
        flag(out_valid == 1'b0, $sformatf("R11 drain: got out_valid=%0b exp 0", out_valid));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule